// File: doc/BRIEF.md
# Parallel Uniform Random Float Source

This block keeps a row of independent 23-bit maximal-length shift-register generators, one per lane. Each enable strobe advances every lane by one step at the same time. The fresh 23-bit word is read as an unsigned binary fraction in [0,1). It is turned into an IEEE754 single-precision number by a leading-one search and a normalising shift. All lanes are converted side by side, and the results are registered together.

The low bits of the same fresh word also leave the block as a population index. That index has log2(POP) bits, and parent-selection logic can use it directly. Lane count, population size, the default seed base and the leading-one search style are parameters. A seed-load strobe replaces the state of every lane with a word taken from a wide input bus.

Top module: `par_rand_float`

## Requirements
- R1: After reset `valid_o` is low and all float and index outputs are zero. Lane i holds its default seed, which is (SEED_BASE + i*23'h1F3D5B) mod 2^23, or 1 when that sum is zero.
- R2: The lane state advances by exactly one step per accepted enable. The step is s' = {s[21:0], s[22]^s[17]}, which is the polynomial x^23+x^18+1. Without an enable the state does not change.
- R3: `valid_o` is high in exactly the cycle after an accepted enable, that is, an enable without a seed load. While `valid_o` is low, the float and index outputs keep their previous values.
- R4: Lane i's float sits at bits [32i+31:32i] and is the conversion of the lane's new word w. The sign is 0. The exponent is 126 minus the number of leading zeros of w in 23 bits. The mantissa is the bits below the leading one, left-aligned in 23 bits. A zero word gives 32'h0.
- R5: Lane i's index sits at bits [IW*i+IW-1:IW*i], where IW = log2(POP). It equals the low IW bits of the lane's new word.
- R6: A seed load copies bits [23i+22:23i] of `seed_word_i` into lane i. A zero word is replaced by that lane's default seed. A seed load takes priority over a simultaneous enable, which is then ignored. A lane state is never zero.
- R7: Lanes step independently. Each lane's output follows only its own seed and the shared enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| seed_load_i | input | 1 | Load all lane states from `seed_word_i` |
| seed_word_i | input | 23*NP | Per-lane seed words |
| enable_i | input | 1 | Advance all lanes and capture new outputs |
| rand_flt_o | output | 32*NP | Per-lane single-precision floats in [0,1) |
| pick_idx_o | output | log2(POP)*NP | Per-lane population indices |
| valid_o | output | 1 | Outputs refreshed in this cycle |

## Verification
A shift-register sequence almost never produces words with many leading zeros or words near all-ones, so the extreme exponents of the converter are hard to reach by free running. The bench reaches them by loading chosen seeds whose next step is a known word: 23'h400000 steps to 1, the smallest nonzero fraction, and 23'h7FFFFF steps to 23'h7FFFFE. The same load puts a zero seed word on one lane, to show the default-seed substitution, and a later load collides with an enable to show that the load wins.

// File: rtl/prng_float_pkg.sv
package prng_float_pkg;
   localparam int RAW_W       = 23;
   localparam int FLT_W       = 32;
   localparam int EXP_W       = 8;
   localparam int TAP_HI      = 22;
   localparam int TAP_LO      = 17;
   localparam int EXP_TOP     = 126;
   localparam logic [RAW_W-1:0] SEED_STRIDE = 23'h1F3D5B;

   typedef struct packed {
      logic             sign;
      logic [EXP_W-1:0] expo;
      logic [RAW_W-1:0] mant;
   } sp_float_t;

   function automatic logic [RAW_W-1:0] lane_seed(input logic [RAW_W-1:0] base,
                                                 input int lane);
      logic [RAW_W-1:0] s;
      s = base + RAW_W'(lane) * SEED_STRIDE;
      return (s == '0) ? RAW_W'(1) : s;
   endfunction
endpackage

// File: rtl/lfsr23_lane.sv
module lfsr23_lane
   import prng_float_pkg::*;
#(
   parameter int               W         = RAW_W,
   parameter logic [W-1:0]     DFLT_SEED = W'(1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] seed_i,
   input  logic         step_i,
   output logic [W-1:0] next_o
);
   if (W != RAW_W) begin : g_bad_w
      $error("lfsr23_lane: feedback taps need W == 23");
   end
   if (DFLT_SEED == '0) begin : g_bad_seed
      $error("lfsr23_lane: default seed must be nonzero");
   end

   logic [W-1:0] state_q;
   logic         fb;

   assign fb     = state_q[TAP_HI] ^ state_q[TAP_LO];
   assign next_o = {state_q[W-2:0], fb};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= DFLT_SEED;
      end else if (load_i) begin
         state_q <= (seed_i == '0) ? DFLT_SEED : seed_i;
      end else if (step_i) begin
         state_q <= next_o;
      end
   end

   AST_STATE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q != '0); // R6

   AST_STEP_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i) |=> state_q == {$past(state_q[W-2:0]),
                                          $past(state_q[TAP_HI]) ^ $past(state_q[TAP_LO])}); // R2

   AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !load_i) |=> $stable(state_q)); // R2
endmodule

// File: rtl/frac_to_sp.sv
module frac_to_sp
   import prng_float_pkg::*;
#(
   parameter int W           = RAW_W,
   parameter int LZC_VARIANT = 0
) (
   input  logic [W-1:0]     raw_i,
   output logic [FLT_W-1:0] flt_o
);
   localparam int LZ_W = $clog2(W + 2);

   if (W != RAW_W) begin : g_bad_w
      $error("frac_to_sp: raw width must match the mantissa width");
   end
   if (LZC_VARIANT < 0 || LZC_VARIANT > 1) begin : g_bad_var
      $error("frac_to_sp: LZC_VARIANT must be 0 or 1");
   end

   logic [LZ_W-1:0] lzc;
   logic [W-1:0]    shifted;
   sp_float_t       res;

   if (LZC_VARIANT == 0) begin : g_scan
      always_comb begin
         logic found;
         found = 1'b0;
         lzc   = LZ_W'(W);
         for (int i = W - 1; i >= 0; i--) begin
            if (!found && raw_i[i]) begin
               lzc   = LZ_W'(W - 1 - i);
               found = 1'b1;
            end
         end
      end
   end else begin : g_smear
      logic [W-1:0]    smear;
      logic [W-1:0]    lead;
      logic [LZ_W-1:0] pos;
      always_comb begin
         smear = raw_i;
         for (int k = 1; k < W; k = k * 2) begin
            smear = smear | (smear >> k);
         end
         lead = smear & ~(smear >> 1);
         pos  = '0;
         for (int i = 0; i < W; i++) begin
            if (lead[i]) pos = pos | LZ_W'(i);
         end
         lzc = (raw_i == '0) ? LZ_W'(W) : LZ_W'(W - 1) - pos;
      end
   end

   always_comb begin
      shifted  = raw_i << (lzc + 1'b1);
      res.sign = 1'b0;
      res.expo = (raw_i == '0) ? '0 : EXP_W'(EXP_TOP - int'(lzc));
      res.mant = (raw_i == '0) ? '0 : shifted;
      flt_o    = res;
   end

   always_comb begin
      if (raw_i == '0) begin
         AST_ZERO_TO_PZERO: assert (flt_o == '0); // R4
      end
   end
endmodule

// File: rtl/par_rand_float.sv
module par_rand_float
   import prng_float_pkg::*;
#(
   parameter int               NP          = 4,
   parameter int               POP         = 32,
   parameter logic [22:0]      SEED_BASE   = 23'h5A5A5A,
   parameter int               LZC_VARIANT = 0
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         seed_load_i,
   input  logic [NP*23-1:0]             seed_word_i,
   input  logic                         enable_i,
   output logic [NP*32-1:0]             rand_flt_o,
   output logic [NP*$clog2(POP)-1:0]    pick_idx_o,
   output logic                         valid_o
);
   localparam int IW = $clog2(POP);

   if (NP < 1) begin : g_bad_np
      $error("par_rand_float: NP must be at least 1");
   end
   if (POP < 2 || (POP & (POP - 1)) != 0) begin : g_bad_pop
      $error("par_rand_float: POP must be a power of two, at least 2");
   end
   if (IW > RAW_W) begin : g_bad_iw
      $error("par_rand_float: index wider than the raw word");
   end

   logic step;
   assign step = enable_i & ~seed_load_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) valid_o <= 1'b0;
      else         valid_o <= step;
   end

   for (genvar g = 0; g < NP; g++) begin : g_lane
      localparam logic [RAW_W-1:0] LSEED = lane_seed(SEED_BASE, g);

      logic [RAW_W-1:0] nxt;
      logic [FLT_W-1:0] flt;

      lfsr23_lane #(.W(RAW_W), .DFLT_SEED(LSEED)) u_lfsr (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .load_i (seed_load_i),
         .seed_i (seed_word_i[g*RAW_W +: RAW_W]),
         .step_i (step),
         .next_o (nxt)
      );

      frac_to_sp #(.W(RAW_W), .LZC_VARIANT(LZC_VARIANT)) u_conv (
         .raw_i (nxt),
         .flt_o (flt)
      );

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            rand_flt_o[g*FLT_W +: FLT_W] <= '0;
            pick_idx_o[g*IW +: IW]       <= '0;
         end else if (step) begin
            rand_flt_o[g*FLT_W +: FLT_W] <= flt;
            pick_idx_o[g*IW +: IW]       <= nxt[IW-1:0];
         end
      end

      AST_SIGN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_o |-> !rand_flt_o[g*FLT_W + FLT_W - 1]); // R4
   end

   AST_VALID_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step |=> valid_o); // R3

   AST_VALID_NEEDS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step |=> !valid_o); // R3

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step |=> ($stable(rand_flt_o) && $stable(pick_idx_o))); // R3
endmodule

// File: tb/par_rand_float_tb_top.sv
`timescale 1ns/1ps
module par_rand_float_tb_top;
   localparam int NP  = 4;
   localparam int POP = 32;
   localparam int IW  = $clog2(POP);
   localparam logic [22:0] SEED_BASE = 23'h5A5A5A;

   typedef struct {
      logic [NP*32-1:0] f;
      logic [NP*IW-1:0] x;
   } exp_t;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic seed_load_i = 1'b0;
   logic [NP*23-1:0] seed_word_i = '0;
   logic enable_i = 1'b0;
   logic [NP*32-1:0] rand_flt_o;
   logic [NP*IW-1:0] pick_idx_o;
   logic valid_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   exp_t q[$];
   logic [22:0] mdl [NP];
   logic [NP*32-1:0] last_f = '0;
   logic [NP*IW-1:0] last_x = '0;

   always #5 clk = ~clk;

   par_rand_float #(.NP(NP), .POP(POP), .SEED_BASE(SEED_BASE)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .seed_load_i(seed_load_i),
      .seed_word_i(seed_word_i), .enable_i(enable_i),
      .rand_flt_o(rand_flt_o), .pick_idx_o(pick_idx_o), .valid_o(valid_o)
   );

   function automatic logic [22:0] dflt(int i);
      logic [22:0] s;
      s = SEED_BASE + 23'(i) * 23'h1F3D5B;
      return (s == 0) ? 23'd1 : s;
   endfunction

   function automatic logic [31:0] want_flt(logic [22:0] r);
      int p;
      logic [45:0] t;
      if (r == 0) return 32'h0;
      p = 0;
      for (int i = 0; i < 23; i++) if (r[i]) p = i;
      t = {23'b0, r} << (23 - p);
      return {1'b0, 8'(104 + p), t[22:0]};
   endfunction

   function automatic logic [22:0] step_of(logic [22:0] s);
      return {s[21:0], s[22] ^ s[17]};
   endfunction

   task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // driver: one accepted enable per call cycle, pushes expected result
   task automatic run_en(int n);
      for (int k = 0; k < n; k++) begin
         exp_t e;
         @(posedge clk); #1;
         enable_i = 1'b1; seed_load_i = 1'b0;
         for (int i = 0; i < NP; i++) begin
            mdl[i] = step_of(mdl[i]);
            e.f[i*32 +: 32] = want_flt(mdl[i]);
            e.x[i*IW +: IW] = mdl[i][IW-1:0];
         end
         q.push_back(e);
      end
      @(posedge clk); #1;
      enable_i = 1'b0;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         enable_i = 1'b0; seed_load_i = 1'b0;
      end
   endtask

   task automatic load(logic [NP*23-1:0] w, bit with_en);
      @(posedge clk); #1;
      seed_load_i = 1'b1; seed_word_i = w; enable_i = with_en;
      for (int i = 0; i < NP; i++)
         mdl[i] = (w[i*23 +: 23] == 0) ? dflt(i) : w[i*23 +: 23];
      @(posedge clk); #1;
      seed_load_i = 1'b0; enable_i = 1'b0;
   endtask

   // monitor: pops and compares results, checks hold while idle
   always @(negedge clk) begin
      if (rst_ni && !done) begin
         if (valid_o) begin
            if (q.size() == 0) begin
               check(0, "R3", "valid without accepted enable", 128'(valid_o), 128'(0));
            end else begin
               exp_t e;
               e = q.pop_front();
               for (int i = 0; i < NP; i++) begin
                  check(rand_flt_o[i*32 +: 32] == e.f[i*32 +: 32], "R4",
                        "lane float (R2 R7 sequence)", 128'(rand_flt_o[i*32 +: 32]), 128'(e.f[i*32 +: 32]));
                  check(pick_idx_o[i*IW +: IW] == e.x[i*IW +: IW], "R5",
                        "lane index", 128'(pick_idx_o[i*IW +: IW]), 128'(e.x[i*IW +: IW]));
               end
            end
            last_f = rand_flt_o;
            last_x = pick_idx_o;
         end else begin
            check(rand_flt_o == last_f && pick_idx_o == last_x, "R3",
                  "outputs held while valid low", 128'(rand_flt_o), 128'(last_f));
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [NP*23-1:0] w;
      for (int i = 0; i < NP; i++) mdl[i] = dflt(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state at the ports
      check(valid_o == 1'b0, "R1", "valid in reset", 128'(valid_o), 128'(0));
      check(rand_flt_o == '0, "R1", "floats in reset", 128'(rand_flt_o), 128'(0));
      check(pick_idx_o == '0, "R1", "indices in reset", 128'(pick_idx_o), 128'(0));
      @(posedge clk); #1;
      rst_ni = 1'b1;
      idle(2);
      // R1 R2: first steps from default seeds
      run_en(5);
      // R2 R3: gaps do not advance lanes, outputs hold
      idle(3);
      run_en(1);
      idle(2);
      run_en(1);
      // R6: loaded seeds, lane 1 zero -> default; extreme exponents for R4
      w = '0;
      w[0*23 +: 23] = 23'h400000;
      w[1*23 +: 23] = 23'h000000;
      w[2*23 +: 23] = 23'h7FFFFF;
      w[3*23 +: 23] = 23'h000001;
      load(w, 1'b0);
      idle(1);
      run_en(3);
      idle(2);
      // R6: load beats a simultaneous enable
      w[0*23 +: 23] = 23'h123456;
      w[1*23 +: 23] = 23'h400000;
      w[2*23 +: 23] = 23'h000000;
      w[3*23 +: 23] = 23'h2AAAAA;
      load(w, 1'b1);
      idle(2);
      run_en(2);
      // R2 R7: long back-to-back run
      run_en(200);
      idle(3);
      check(q.size() == 0, "R3", "all expected results seen", 128'(q.size()), 128'(0));
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule